// File: doc/BRIEF.md
# Decode-Stage Stall Controller

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline may move on to execute. It is given the decoded register fields of that instruction. It keeps its own two-deep record of the instructions ahead of it: the destination, write flag and load flag of what is now in execute and what is now in memory access. When a source operand cannot yet be supplied by the forwarding network, it freezes the program counter and the fetch/decode register, and it turns the slot entering execute into a bubble.

Two families of dependency are handled. The first is the ordinary interlock for a load whose result is consumed by the very next instruction. The second covers conditional branches, which compare their two registers in decode. Because of this, a branch needs its operands one stage earlier than an ALU instruction would. It must wait on an ALU result produced just before it. It must wait twice on a load produced just before it, and once on a load two slots ahead. Forwarding and the comparator itself sit outside this block.

Top module: `hz_stall_ctrl`

## Requirements
- R1: When the instruction in execute is a load writing a nonzero register that equals a used source (rs with id_use_rs high, or rt with id_use_rt high) of the decode instruction, a stall is raised; for a non-branch consumer it lasts exactly one cycle.
- R2: During a stall the slot entering execute becomes a bubble, so the stalled instruction is not seen as a producer while it waits; an instruction that loads into its own source register stalls only once.
- R3: idex_bubble is high exactly in stall cycles, and pc_we and ifid_we are both low in those cycles and both high in every other cycle.
- R4: A branch (id_branch high) whose compared register is written by the ALU instruction immediately before it stalls for exactly one cycle.
- R5: A branch whose compared register is written by the load immediately before it stalls for exactly two consecutive cycles.
- R6: A branch whose compared register is written by a load two instructions ahead of it stalls for exactly one cycle.
- R7: No stall arises for a branch whose producer is an ALU instruction two or three slots ahead, for a branch whose producer is a load three slots ahead, or for a non-branch consumer whose producer is an ALU instruction at any distance or a load two or more slots ahead.
- R8: A producer whose destination is register 0 never causes a stall.
- R9: Source fields whose use flag is low, and producers whose write flag (id_wr) is low, never cause a stall.
- R10: While reset is held and after it, with no producers recorded, pc_we and ifid_we are high and idex_bubble is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the producer record |
| id_rs | input | 5 | First source register of the decode instruction |
| id_rt | input | 5 | Second source register of the decode instruction |
| id_use_rs | input | 1 | The decode instruction reads id_rs |
| id_use_rt | input | 1 | The decode instruction reads id_rt |
| id_branch | input | 1 | The decode instruction is a branch comparing its sources in decode |
| id_dst | input | 5 | Destination register of the decode instruction |
| id_wr | input | 1 | The decode instruction writes id_dst |
| id_load | input | 1 | The decode instruction reads data memory (a load) |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero the control fields loaded into the execute stage |

## Verification
The embedded properties watch every cycle for the bubble being recorded after a stall, and for stalls whose only matching register is register 0. They also watch that a non-branch instruction held still never stalls twice in a row and that a branch held still never stalls three times in a row. The exact number of stall cycles is a different matter. For each producer kind, distance and consumer kind, and for a self-dependent load, it depends on the history of instructions issued. Only the bench's issued sequences, which sweep those combinations and count the frozen cycles, can show that count.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int unsigned REG_AW      = 5;
    localparam int unsigned TRACK_DEPTH = 2;

    typedef logic [REG_AW-1:0] reg_idx_t;

    // Hazard-relevant summary of one in-flight instruction
    typedef struct packed {
        logic     wr;
        logic     ld;
        reg_idx_t dst;
    } prod_t;

    localparam prod_t PROD_NONE = '0;

    typedef enum logic [2:0] {
        HZ_NONE,
        HZ_LOAD_USE,
        HZ_BR_EX_ALU,
        HZ_BR_EX_LOAD,
        HZ_BR_MEM_LOAD
    } hz_cause_e;

    // True when the producer writes a real register equal to r
    function automatic logic writes_reg(prod_t p, reg_idx_t r);
        return p.wr && (p.dst != '0) && (p.dst == r);
    endfunction

endpackage

// File: rtl/hz_shadow.sv
module hz_shadow
    import hz_pkg::*;
#(
    parameter int unsigned NSTAGE = TRACK_DEPTH
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bubble_i,
    input  prod_t                  entry_i,
    output prod_t [NSTAGE-1:0]     stage_o
);

    prod_t [NSTAGE-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= bubble_i ? PROD_NONE : entry_i;
            for (int s = 1; s < NSTAGE; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign stage_o = stage_q;

    // R2: a stalled slot must enter execute as a bubble
    p_bubble_clears_r2: assert property (@(posedge clk) disable iff (rst)
        bubble_i |=> (stage_q[0] == PROD_NONE));

endmodule

// File: rtl/hz_match.sv
module hz_match
    import hz_pkg::*;
#(
    parameter int unsigned NSTAGE = TRACK_DEPTH
) (
    input  prod_t [NSTAGE-1:0] stage_i,
    input  reg_idx_t           rs_i,
    input  reg_idx_t           rt_i,
    input  logic               use_rs_i,
    input  logic               use_rt_i,
    output logic [NSTAGE-1:0]  hit_o,
    output logic [NSTAGE-1:0]  hit_ld_o
);

    for (genvar s = 0; s < NSTAGE; s++) begin : g_cmp
        logic rs_hit;
        logic rt_hit;
        assign rs_hit      = use_rs_i && writes_reg(stage_i[s], rs_i);
        assign rt_hit      = use_rt_i && writes_reg(stage_i[s], rt_i);
        assign hit_o[s]    = rs_hit || rt_hit;
        assign hit_ld_o[s] = (rs_hit || rt_hit) && stage_i[s].ld;
    end

endmodule

// File: rtl/hz_rules.sv
module hz_rules
    import hz_pkg::*;
#(
    parameter int unsigned NSTAGE = TRACK_DEPTH
) (
    input  logic [NSTAGE-1:0] hit_i,
    input  logic [NSTAGE-1:0] hit_ld_i,
    input  logic              branch_i,
    output logic              stall_o
);

    localparam int unsigned EX_SLOT  = 0;
    localparam int unsigned MEM_SLOT = 1;

    hz_cause_e cause;

    always_comb begin
        cause = HZ_NONE;
        if (hit_ld_i[EX_SLOT]) begin
            cause = branch_i ? HZ_BR_EX_LOAD : HZ_LOAD_USE;
        end else if (branch_i && hit_i[EX_SLOT]) begin
            cause = HZ_BR_EX_ALU;
        end else if (branch_i && hit_ld_i[MEM_SLOT]) begin
            cause = HZ_BR_MEM_LOAD;
        end
    end

    assign stall_o = (cause != HZ_NONE);

endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
    import hz_pkg::*;
#(
    parameter int unsigned NSTAGE = TRACK_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic              id_use_rs,
    input  logic              id_use_rt,
    input  logic              id_branch,
    input  logic [REG_AW-1:0] id_dst,
    input  logic              id_wr,
    input  logic              id_load,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              idex_bubble
);

    prod_t              entry;
    prod_t [NSTAGE-1:0] stages;
    logic  [NSTAGE-1:0] hit;
    logic  [NSTAGE-1:0] hit_ld;
    logic               stall;

    assign entry = '{wr: id_wr, ld: id_load && id_wr, dst: id_dst};

    hz_shadow #(.NSTAGE(NSTAGE)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .bubble_i (stall),
        .entry_i  (entry),
        .stage_o  (stages)
    );

    hz_match #(.NSTAGE(NSTAGE)) u_match (
        .stage_i  (stages),
        .rs_i     (id_rs),
        .rt_i     (id_rt),
        .use_rs_i (id_use_rs),
        .use_rt_i (id_use_rt),
        .hit_o    (hit),
        .hit_ld_o (hit_ld)
    );

    hz_rules #(.NSTAGE(NSTAGE)) u_rules (
        .hit_i    (hit),
        .hit_ld_i (hit_ld),
        .branch_i (id_branch),
        .stall_o  (stall)
    );

    assign pc_we       = !stall;
    assign ifid_we     = !stall;
    assign idex_bubble = stall;

    logic [2*REG_AW+2:0] dec_bundle;
    assign dec_bundle = {id_rs, id_rt, id_use_rs, id_use_rt, id_branch};

    // R1: a held non-branch consumer is frozen for one cycle only
    p_load_use_once_r1: assert property (@(posedge clk) disable iff (rst)
        (idex_bubble && !id_branch) |=> (!idex_bubble || !$stable(dec_bundle)));

    // R5: a held branch is never frozen for a third consecutive cycle
    p_branch_max_two_r5: assert property (@(posedge clk) disable iff (rst)
        (idex_bubble && $past(idex_bubble) && $stable(dec_bundle))
        |=> (!idex_bubble || !$stable(dec_bundle)));

    // R8: a stall always involves a used, nonzero source register
    p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |-> ((id_use_rs && id_rs != '0) || (id_use_rt && id_rt != '0)));

endmodule

// File: tb/hz_stall_ctrl_tb.sv
`timescale 1ns/1ps
module hz_stall_ctrl_tb_top;
    import hz_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst;
    reg_idx_t   id_rs, id_rt, id_dst;
    logic       id_use_rs, id_use_rt, id_branch, id_wr, id_load;
    logic       pc_we, ifid_we, idex_bubble;

    hz_stall_ctrl dut_i (
        .clk(clk), .rst(rst),
        .id_rs(id_rs), .id_rt(id_rt),
        .id_use_rs(id_use_rs), .id_use_rt(id_use_rt),
        .id_branch(id_branch), .id_dst(id_dst),
        .id_wr(id_wr), .id_load(id_load),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble)
    );

    typedef struct {
        reg_idx_t rs, rt, dst;
        logic urs, urt, br, wr, ld;
    } ins_t;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic ins_t mk_nop();
        ins_t i;
        i.rs = '0; i.rt = '0; i.dst = '0;
        i.urs = 0; i.urt = 0; i.br = 0; i.wr = 0; i.ld = 0;
        return i;
    endfunction

    task automatic apply(input ins_t i);
        id_rs = i.rs; id_rt = i.rt; id_dst = i.dst;
        id_use_rs = i.urs; id_use_rt = i.urt; id_branch = i.br;
        id_wr = i.wr; id_load = i.ld;
    endtask

    // Present one instruction until it is accepted; count frozen cycles
    task automatic issue(input ins_t i, output int stalls, output int en_bad);
        bit held;
        stalls = 0;
        en_bad = 0;
        apply(i);
        held = 1;
        while (held) begin
            #1;
            if (pc_we !== !idex_bubble || ifid_we !== !idex_bubble) en_bad++;
            held = (idex_bubble === 1'b1);
            @(posedge clk);
            @(negedge clk);
            if (held) stalls++;
            if (stalls > 8) held = 0;
        end
    endtask

    task automatic drain();
        int s, b;
        for (int k = 0; k < 3; k++) issue(mk_nop(), s, b);
    endtask

    // Expected stall cycles from the requirements
    function automatic int exp_stalls(bit ld, bit br, int d, bit zero);
        if (zero) return 0;
        if (br && ld)  return (d == 1) ? 2 : (d == 2) ? 1 : 0;
        if (br && !ld) return (d == 1) ? 1 : 0;
        if (!br && ld) return (d == 1) ? 1 : 0;
        return 0;
    endfunction

    function automatic string req_tag(bit ld, bit br, int d, bit zero);
        if (zero)                  return "R8";
        if (!br && ld && d == 1)   return "R1";
        if (br && !ld && d == 1)   return "R4";
        if (br && ld && d == 1)    return "R5";
        if (br && ld && d == 2)    return "R6";
        return "R7";
    endfunction

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int s, b;
        ins_t p, c;
        rst = 1'b1;
        apply(mk_nop());
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 pc_we in reset", int'(pc_we), 1);
        chk("R10 ifid_we in reset", int'(ifid_we), 1);
        chk("R10 idex_bubble in reset", int'(idex_bubble), 0);
        rst = 1'b0;
        issue(mk_nop(), s, b);
        chk("R10 no stall after reset", s, 0);

        // Sweep: producer kind, consumer kind, distance, operand slot, zero register
        for (int ld = 0; ld < 2; ld++)
        for (int br = 0; br < 2; br++)
        for (int d = 1; d <= 3; d++)
        for (int op = 0; op < 2; op++)
        for (int z = 0; z < 2; z++) begin
            reg_idx_t r;
            r = (z != 0) ? reg_idx_t'(0) : reg_idx_t'(7);
            drain();
            p = mk_nop();
            p.rs = 1; p.rt = 2; p.urs = 1; p.urt = 1;
            p.wr = 1; p.ld = ld[0]; p.dst = r;
            issue(p, s, b);
            for (int k = 1; k < d; k++) issue(mk_nop(), s, b);
            c = mk_nop();
            c.urs = 1; c.urt = 1; c.br = br[0];
            c.rs = (op == 0) ? r : reg_idx_t'(3);
            c.rt = (op == 0) ? reg_idx_t'(3) : r;
            if (br == 0) begin c.wr = 1; c.dst = 9; end
            issue(c, s, b);
            chk($sformatf("%s stalls ld=%0d br=%0d dist=%0d op=%0d zero=%0d",
                 req_tag(ld[0], br[0], d, z[0]), ld, br, d, op, z),
                s, exp_stalls(ld[0], br[0], d, z[0]));
            chk("R3 enables follow bubble", b, 0);
        end

        // R2: load that reads its own destination stalls once
        drain();
        p = mk_nop(); p.rs = 1; p.urs = 1; p.wr = 1; p.ld = 1; p.dst = 4;
        issue(p, s, b);
        p.rs = 4;
        issue(p, s, b);
        chk("R2 self-load stalls once", s, 1);
        c = mk_nop(); c.rs = 4; c.urs = 1; c.wr = 1; c.dst = 6;
        issue(c, s, b);
        chk("R1 consumer after self-load", s, 1);

        // R9: non-writing producer and unused source fields
        drain();
        p = mk_nop(); p.wr = 0; p.dst = 7;
        issue(p, s, b);
        c = mk_nop(); c.br = 1; c.rs = 7; c.rt = 7; c.urs = 1; c.urt = 1;
        issue(c, s, b);
        chk("R9 non-writing producer", s, 0);
        drain();
        p = mk_nop(); p.wr = 1; p.ld = 1; p.dst = 7;
        issue(p, s, b);
        c = mk_nop(); c.rs = 7; c.rt = 7; c.wr = 1; c.dst = 8;
        issue(c, s, b);
        chk("R9 unused source fields", s, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule